// File: doc/BRIEF.md
# Multi-Level Banked Register File

This block keeps a separate set of working registers for every program priority level of a processor. With the defaults there are 16 levels of 16 registers, 256 registers in all. The active level's set is held in a working copy, which the datapath reads and writes. A level switch takes a fixed number of cycles. It first writes the working copy back into bank storage under the old level. It then fills the working copy from the bank of the new level. The registers of every other level stay in storage while their level is inactive.

There are two access ports. The microprogram port reaches all registers of the active level. The instruction port reaches only the lower half of the set, and the block refuses anything it asks for above that.

The block also holds a 16-bit status word. Its upper nibble is shared by all levels. Its level field shows the active level. Its lower byte is kept separately for each level and contains the carry, dynamic overflow, static overflow and error flags. The error flag of the active level drives an interrupt request output. Software can read and write the status word as a whole.

Top module: `lbr_bank_rf`

## Requirements
- R1: After reset every register of every level reads zero, the active level is 0, `busy` is low, the status word is 0x0000 and `err_irq` is low.
- R2: The microprogram port writes any working register index 0..15 on a clock edge while idle. A read of that index returns the new value from the next cycle, with `mc_rd_ok` high.
- R3: The instruction port serves only indexes 0..7. A read of index 8..15 returns `ins_rd_ok` = 0 and data 0. An instruction write to index 8..15 is ignored. When both ports write in the same cycle, only the microprogram write takes effect.
- R4: A level switch request accepted while idle raises `busy` in the next cycle. `busy` then stays high for exactly 32 cycles (twice the registers per level). `level` takes the requested value in the cycle `busy` falls. A switch request made while `busy` is high is ignored.
- R5: While `busy` is high, both read ports give ok = 0 and data 0. Register writes, status word writes and flag updates are all ignored during that time.
- R6: On returning to a level, its registers hold the values they had when that level was left. A level that has never been active shows all zeros.
- R7: The status word places the shared nibble in bits 15:12, the active level in bits 11:8 and the per-level byte in bits 7:0. A word write updates bits 15:12 and 7:0 and ignores bits 11:8.
- R8: A flag update sets carry (bit 0) and dynamic overflow (bit 1) to the values of that update. Static overflow (bit 2) is set by an update that reports overflow and stays set until a word write clears it.
- R9: Error (bit 3) is set by an update that reports an error and stays set until a word write clears it. `err_irq` equals the error flag of the active level.
- R10: The per-level byte of each level is preserved across switches, while the shared nibble is common to all levels. A word write and a flag update in the same cycle leave exactly the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req | input | 1 | Request a level switch |
| sw_level | input | 4 | Level to switch to |
| busy | output | 1 | Level switch in progress |
| level | output | 4 | Active program level |
| mc_wr_en | input | 1 | Microprogram register write |
| mc_wr_idx | input | 4 | Microprogram write index |
| mc_wr_data | input | 16 | Microprogram write data |
| mc_rd_idx | input | 4 | Microprogram read index |
| mc_rd_data | output | 16 | Microprogram read data |
| mc_rd_ok | output | 1 | Microprogram read valid |
| ins_wr_en | input | 1 | Instruction register write |
| ins_wr_idx | input | 4 | Instruction write index |
| ins_wr_data | input | 16 | Instruction write data |
| ins_rd_idx | input | 4 | Instruction read index |
| ins_rd_data | output | 16 | Instruction read data |
| ins_rd_ok | output | 1 | Instruction read valid (index allowed, not busy) |
| st_wr_en | input | 1 | Status word write |
| st_wr_data | input | 16 | Status word write data |
| st_rd_data | output | 16 | Status word of active level |
| alu_upd | input | 1 | Flag update strobe |
| alu_carry | input | 1 | Carry result |
| alu_ovf | input | 1 | Overflow result |
| alu_err | input | 1 | Error event |
| err_irq | output | 1 | Error flag of active level |

## Verification
The hardest situation to reach is traffic that arrives inside the switch window: register writes, status writes, flag updates and a second switch request that all land while the save and load sequence is running. The bench drives all of these together in the first busy cycle of one switch. It then shows that none of them took effect, by looking at the new level, its zeroed registers and its status word. The restore path can only be seen after a round trip, so the bench visits a level, leaves it, later returns and reads back every register and the per-level flags. It also switches to the level that is already active and to the highest level.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
   typedef enum logic [1:0] {SQ_IDLE, SQ_SAVE, SQ_LOAD} seq_state_e;

   localparam int STS_W          = 16;
   localparam int STS_C          = 0;
   localparam int STS_Q          = 1;
   localparam int STS_O          = 2;
   localparam int STS_Z          = 3;
   localparam int STS_LO_W       = 8;
   localparam int STS_LVL_LSB    = 8;
   localparam int STS_LVL_W      = 4;
   localparam int STS_SHARED_LSB = 12;
   localparam int STS_SHARED_W   = 4;
endpackage

// File: rtl/lbr_store.sv
module lbr_store #(
   parameter int LEVELS = 16,
   parameter int REGS   = 16,
   parameter int DATA_W = 16,
   localparam int LW    = $clog2(LEVELS),
   localparam int RW    = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LW-1:0]     wr_lvl,
   input  logic [RW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LW-1:0]     rd_lvl,
   input  logic [RW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = LEVELS * REGS;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[{wr_lvl, wr_idx}] <= wr_data;
      end
   end

   assign rd_data = mem_q[{rd_lvl, rd_idx}];
endmodule

// File: rtl/lbr_switch_seq.sv
module lbr_switch_seq
   import lbr_pkg::*;
#(
   parameter int LEVELS = 16,
   parameter int REGS   = 16,
   localparam int LW    = $clog2(LEVELS),
   localparam int RW    = $clog2(REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [LW-1:0] req_lvl,
   output logic          busy,
   output logic          save_we,
   output logic          load_we,
   output logic [RW-1:0] step_idx,
   output logic [LW-1:0] cur_lvl,
   output logic [LW-1:0] tgt_lvl
);
   localparam logic [RW-1:0] LAST_IDX = RW'(REGS - 1);
   localparam int            SW_CYCLES = 2 * REGS;

   seq_state_e    state_q;
   logic [RW-1:0] idx_q;
   logic [LW-1:0] cur_q, tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         cur_q   <= '0;
         tgt_q   <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (req) begin
               state_q <= SQ_SAVE;
               idx_q   <= '0;
               tgt_q   <= req_lvl;
            end
            SQ_SAVE: if (idx_q == LAST_IDX) begin
               state_q <= SQ_LOAD;
               idx_q   <= '0;
            end else begin
               idx_q <= idx_q + RW'(1);
            end
            SQ_LOAD: if (idx_q == LAST_IDX) begin
               state_q <= SQ_IDLE;
               idx_q   <= '0;
               cur_q   <= tgt_q;
            end else begin
               idx_q <= idx_q + RW'(1);
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != SQ_IDLE);
   assign save_we  = (state_q == SQ_SAVE);
   assign load_we  = (state_q == SQ_LOAD);
   assign step_idx = idx_q;
   assign cur_lvl  = cur_q;
   assign tgt_lvl  = tgt_q;

   // window length checker for R4
   int chk_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    chk_cnt <= 0;
      else if (busy) chk_cnt <= chk_cnt + 1;
      else           chk_cnt <= 0;
   end

   p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req) |=> busy);
   p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(cur_lvl));
   p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (chk_cnt == SW_CYCLES));
endmodule

// File: rtl/lbr_status.sv
module lbr_status
   import lbr_pkg::*;
#(
   parameter int LEVELS = 16,
   localparam int LW    = $clog2(LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    cur_lvl,
   input  logic             hold,
   input  logic             wr_en,
   input  logic [STS_W-1:0] wr_data,
   input  logic             upd_en,
   input  logic             upd_carry,
   input  logic             upd_ovf,
   input  logic             upd_err,
   output logic [STS_W-1:0] word,
   output logic             err_flag
);
   logic [STS_LO_W-1:0]     lo_q [LEVELS];
   logic [STS_SHARED_W-1:0] sh_q;
   logic [STS_LO_W-1:0]     lo_cur;
   logic                    unused_lvl_bits;

   assign lo_cur          = lo_q[cur_lvl];
   assign unused_lvl_bits = ^wr_data[STS_LVL_LSB +: STS_LVL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         for (int i = 0; i < LEVELS; i++) lo_q[i] <= '0;
      end else if (!hold) begin
         if (wr_en) begin
            sh_q          <= wr_data[STS_SHARED_LSB +: STS_SHARED_W];
            lo_q[cur_lvl] <= wr_data[STS_LO_W-1:0];
         end else if (upd_en) begin
            lo_q[cur_lvl][STS_C] <= upd_carry;
            lo_q[cur_lvl][STS_Q] <= upd_ovf;
            lo_q[cur_lvl][STS_O] <= lo_cur[STS_O] | upd_ovf;
            lo_q[cur_lvl][STS_Z] <= lo_cur[STS_Z] | upd_err;
         end
      end
   end

   assign word     = {sh_q, STS_LVL_W'(cur_lvl), lo_cur};
   assign err_flag = lo_cur[STS_Z];

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (word[STS_O] && !wr_en && !hold) |=> word[STS_O]);
   p_dyn_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !wr_en && upd_en) |=> (word[STS_Q] == $past(upd_ovf)));
   p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !wr_en && upd_en && upd_err) |=> err_flag);
endmodule

// File: rtl/lbr_bank_rf.sv
module lbr_bank_rf
   import lbr_pkg::*;
#(
   parameter int LEVELS   = 16,
   parameter int REGS     = 16,
   parameter int LOW_REGS = 8,
   parameter int DATA_W   = 16,
   localparam int LW      = $clog2(LEVELS),
   localparam int RW      = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req,
   input  logic [LW-1:0]     sw_level,
   output logic              busy,
   output logic [LW-1:0]     level,
   input  logic              mc_wr_en,
   input  logic [RW-1:0]     mc_wr_idx,
   input  logic [DATA_W-1:0] mc_wr_data,
   input  logic [RW-1:0]     mc_rd_idx,
   output logic [DATA_W-1:0] mc_rd_data,
   output logic              mc_rd_ok,
   input  logic              ins_wr_en,
   input  logic [RW-1:0]     ins_wr_idx,
   input  logic [DATA_W-1:0] ins_wr_data,
   input  logic [RW-1:0]     ins_rd_idx,
   output logic [DATA_W-1:0] ins_rd_data,
   output logic              ins_rd_ok,
   input  logic              st_wr_en,
   input  logic [15:0]       st_wr_data,
   output logic [15:0]       st_rd_data,
   input  logic              alu_upd,
   input  logic              alu_carry,
   input  logic              alu_ovf,
   input  logic              alu_err,
   output logic              err_irq
);
   // elaboration checks
   if (LEVELS < 2 || (1 << LW) != LEVELS || LW > STS_LVL_W) begin : g_bad_levels
      $error("LEVELS must be a power of two from 2 to 16");
   end
   if (REGS < 2 || (1 << RW) != REGS) begin : g_bad_regs
      $error("REGS must be a power of two, at least 2");
   end
   if (LOW_REGS < 1 || LOW_REGS > REGS) begin : g_bad_low
      $error("LOW_REGS must lie in 1..REGS");
   end

   logic              save_we, load_we;
   logic [RW-1:0]     step_idx;
   logic [LW-1:0]     cur_lvl, tgt_lvl;
   logic [DATA_W-1:0] store_rd;
   logic [DATA_W-1:0] work_q [REGS];
   logic              ins_wr_allow, ins_rd_allow;

   lbr_switch_seq #(.LEVELS(LEVELS), .REGS(REGS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (sw_req),
      .req_lvl  (sw_level),
      .busy     (busy),
      .save_we  (save_we),
      .load_we  (load_we),
      .step_idx (step_idx),
      .cur_lvl  (cur_lvl),
      .tgt_lvl  (tgt_lvl)
   );

   lbr_store #(.LEVELS(LEVELS), .REGS(REGS), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (save_we),
      .wr_lvl  (cur_lvl),
      .wr_idx  (step_idx),
      .wr_data (work_q[step_idx]),
      .rd_lvl  (tgt_lvl),
      .rd_idx  (step_idx),
      .rd_data (store_rd)
   );

   lbr_status #(.LEVELS(LEVELS)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur_lvl   (cur_lvl),
      .hold      (busy),
      .wr_en     (st_wr_en),
      .wr_data   (st_wr_data),
      .upd_en    (alu_upd),
      .upd_carry (alu_carry),
      .upd_ovf   (alu_ovf),
      .upd_err   (alu_err),
      .word      (st_rd_data),
      .err_flag  (err_irq)
   );

   // instruction-port reach: whole set or lower part only
   if (LOW_REGS == REGS) begin : g_full_reach
      assign ins_wr_allow = 1'b1;
      assign ins_rd_allow = 1'b1;
   end else begin : g_split_reach
      assign ins_wr_allow = (ins_wr_idx < RW'(LOW_REGS));
      assign ins_rd_allow = (ins_rd_idx < RW'(LOW_REGS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REGS; i++) work_q[i] <= '0;
      end else if (load_we) begin
         work_q[step_idx] <= store_rd;
      end else if (!busy) begin
         if (mc_wr_en)                       work_q[mc_wr_idx]  <= mc_wr_data;
         else if (ins_wr_en && ins_wr_allow) work_q[ins_wr_idx] <= ins_wr_data;
      end
   end

   always_comb begin
      mc_rd_ok    = !busy;
      mc_rd_data  = busy ? '0 : work_q[mc_rd_idx];
      ins_rd_ok   = !busy && ins_rd_allow;
      ins_rd_data = ins_rd_ok ? work_q[ins_rd_idx] : '0;
   end

   assign level = cur_lvl;

   p_read_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!mc_rd_ok && !ins_rd_ok));
   p_upper_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sw_req && !mc_wr_en && ins_wr_en && !ins_wr_allow
       && (mc_rd_idx == ins_wr_idx))
      |=> ((mc_rd_idx != $past(mc_rd_idx)) || (mc_rd_data == $past(mc_rd_data))));
   p_level_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (level == $past(tgt_lvl)));
endmodule

// File: tb/lbr_bank_rf_test.sv
`timescale 1ns/1ps
module lbr_bank_rf_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_req = 1'b0;
   logic [3:0]  sw_level = '0;
   logic        busy;
   logic [3:0]  level;
   logic        mc_wr_en = 1'b0;
   logic [3:0]  mc_wr_idx = '0;
   logic [15:0] mc_wr_data = '0;
   logic [3:0]  mc_rd_idx = '0;
   logic [15:0] mc_rd_data;
   logic        mc_rd_ok;
   logic        ins_wr_en = 1'b0;
   logic [3:0]  ins_wr_idx = '0;
   logic [15:0] ins_wr_data = '0;
   logic [3:0]  ins_rd_idx = '0;
   logic [15:0] ins_rd_data;
   logic        ins_rd_ok;
   logic        st_wr_en = 1'b0;
   logic [15:0] st_wr_data = '0;
   logic [15:0] st_rd_data;
   logic        alu_upd = 1'b0, alu_carry = 1'b0, alu_ovf = 1'b0, alu_err = 1'b0;
   logic        err_irq;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lbr_bank_rf uut (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_level(sw_level),
      .busy(busy), .level(level),
      .mc_wr_en(mc_wr_en), .mc_wr_idx(mc_wr_idx), .mc_wr_data(mc_wr_data),
      .mc_rd_idx(mc_rd_idx), .mc_rd_data(mc_rd_data), .mc_rd_ok(mc_rd_ok),
      .ins_wr_en(ins_wr_en), .ins_wr_idx(ins_wr_idx), .ins_wr_data(ins_wr_data),
      .ins_rd_idx(ins_rd_idx), .ins_rd_data(ins_rd_data), .ins_rd_ok(ins_rd_ok),
      .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .st_rd_data(st_rd_data),
      .alu_upd(alu_upd), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
      .alu_err(alu_err), .err_irq(err_irq)
   );

   // scoreboard: sel 0 mc data, 1 mc ok, 2 ins data, 3 ins ok, 4 status,
   // 5 level, 6 busy, 7 err_irq, 8 value captured by the driver
   typedef struct {
      string       tag;
      int          sel;
      logic [15:0] exp;
      logic [15:0] aux;
   } item_t;
   item_t sb_q[$];

   always @(negedge clk) begin : monitor
      item_t       it;
      logic [15:0] act;
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         case (it.sel)
            0: act = mc_rd_data;
            1: act = {15'b0, mc_rd_ok};
            2: act = ins_rd_data;
            3: act = {15'b0, ins_rd_ok};
            4: act = st_rd_data;
            5: act = {12'b0, level};
            6: act = {15'b0, busy};
            7: act = {15'b0, err_irq};
            default: act = it.aux;
         endcase
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic push(int sel, logic [15:0] exp, logic [15:0] aux, string tag);
      item_t it;
      it.tag = tag; it.sel = sel; it.exp = exp; it.aux = aux;
      sb_q.push_back(it);
   endtask

   task automatic chk_sig(int sel, logic [15:0] exp, string tag);
      push(sel, exp, '0, tag);
      tick();
   endtask

   task automatic chk_mc(int idx, logic [15:0] exp, string tag);
      mc_rd_idx = 4'(idx);
      push(1, 16'd1, '0, tag);
      push(0, exp, '0, tag);
      tick();
   endtask

   task automatic chk_ins(int idx, logic [15:0] exp, logic ok, string tag);
      ins_rd_idx = 4'(idx);
      push(3, {15'b0, ok}, '0, tag);
      push(2, exp, '0, tag);
      tick();
   endtask

   task automatic mc_write(int idx, logic [15:0] val);
      mc_wr_en = 1'b1; mc_wr_idx = 4'(idx); mc_wr_data = val;
      tick();
      mc_wr_en = 1'b0;
   endtask

   task automatic ins_write(int idx, logic [15:0] val);
      ins_wr_en = 1'b1; ins_wr_idx = 4'(idx); ins_wr_data = val;
      tick();
      ins_wr_en = 1'b0;
   endtask

   task automatic alu(logic c, logic o, logic e);
      alu_upd = 1'b1; alu_carry = c; alu_ovf = o; alu_err = e;
      tick();
      alu_upd = 1'b0; alu_carry = 1'b0; alu_ovf = 1'b0; alu_err = 1'b0;
   endtask

   task automatic st_write(logic [15:0] val);
      st_wr_en = 1'b1; st_wr_data = val;
      tick();
      st_wr_en = 1'b0;
   endtask

   task automatic do_switch(int lvl, bit disturb);
      int cnt = 0;
      sw_req = 1'b1; sw_level = 4'(lvl);
      tick();
      sw_req = 1'b0;
      if (disturb) begin
         mc_rd_idx = 4'd0; ins_rd_idx = 4'd0;
         push(1, 16'd0, '0, "R5 mc read stalled");
         push(0, 16'd0, '0, "R5 mc data zero while busy");
         push(3, 16'd0, '0, "R5 ins read stalled");
         mc_wr_en = 1'b1; mc_wr_idx = 4'd0; mc_wr_data = 16'hBEEF;
         sw_req = 1'b1; sw_level = 4'd7;
         alu_upd = 1'b1; alu_err = 1'b1; alu_carry = 1'b1;
         st_wr_en = 1'b1; st_wr_data = 16'hFFFF;
      end
      while (busy && cnt < 100) begin
         cnt++;
         tick();
         mc_wr_en = 1'b0; sw_req = 1'b0; alu_upd = 1'b0; alu_err = 1'b0;
         alu_carry = 1'b0; st_wr_en = 1'b0;
      end
      push(8, 16'd32, 16'(cnt), "R4 busy length");
      push(5, 16'(lvl), '0, "R4 level after switch");
      tick();
   endtask

   logic [15:0] exp0 [16];
   logic [15:0] exp3 [16];

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      chk_sig(5, 16'd0, "R1 level");
      chk_sig(6, 16'd0, "R1 busy");
      chk_sig(4, 16'h0000, "R1 status");
      chk_sig(7, 16'd0, "R1 err_irq");
      chk_mc(9, 16'h0000, "R1 register zero");

      // R2 microprogram port, all indexes
      for (int i = 0; i < 16; i++) begin
         exp0[i] = 16'(16'h1000 + i * 37);
         mc_write(i, exp0[i]);
      end
      for (int i = 0; i < 16; i++) chk_mc(i, exp0[i], "R2 readback");

      // R3 instruction port reach
      chk_ins(3, exp0[3], 1'b1, "R3 lower read");
      chk_ins(12, 16'h0000, 1'b0, "R3 upper read refused");
      ins_write(2, 16'h2222); exp0[2] = 16'h2222;
      chk_mc(2, exp0[2], "R3 lower write");
      ins_write(10, 16'hDEAD);
      chk_mc(10, exp0[10], "R3 upper write ignored");
      mc_wr_en = 1'b1; mc_wr_idx = 4'd4; mc_wr_data = 16'h4444;
      ins_wr_en = 1'b1; ins_wr_idx = 4'd5; ins_wr_data = 16'h5555;
      tick();
      mc_wr_en = 1'b0; ins_wr_en = 1'b0;
      exp0[4] = 16'h4444;
      chk_mc(4, exp0[4], "R3 mc write wins");
      chk_mc(5, exp0[5], "R3 ins write dropped");

      // R8 / R9 flags
      alu(1'b1, 1'b1, 1'b0);
      chk_sig(4, 16'h0007, "R8 carry dyn static set");
      alu(1'b0, 1'b0, 1'b0);
      chk_sig(4, 16'h0004, "R8 static overflow sticky");
      alu(1'b0, 1'b0, 1'b1);
      chk_sig(4, 16'h000C, "R9 error set");
      chk_sig(7, 16'd1, "R9 err_irq");
      alu(1'b0, 1'b0, 1'b0);
      chk_sig(4, 16'h000C, "R9 error sticky");

      // R7 word transfer, level field read-only
      st_write(16'h9FA0);
      chk_sig(4, 16'h90A0, "R7 word write");
      chk_sig(7, 16'd0, "R9 err cleared by word");

      // R10 word write beats flag update
      st_wr_en = 1'b1; st_wr_data = 16'h9030;
      alu_upd = 1'b1; alu_carry = 1'b1; alu_ovf = 1'b1; alu_err = 1'b1;
      tick();
      st_wr_en = 1'b0; alu_upd = 1'b0; alu_carry = 1'b0; alu_ovf = 1'b0; alu_err = 1'b0;
      chk_sig(4, 16'h9030, "R10 word write priority");
      st_write(16'h5008);
      chk_sig(4, 16'h5008, "R7 word write");

      // R4 / R5 switch with traffic inside the window
      do_switch(3, 1'b1);
      chk_sig(4, 16'h5300, "R10 shared kept, fresh level byte");
      chk_sig(7, 16'd0, "R5 flag update ignored");
      chk_mc(0, 16'h0000, "R5 write during switch ignored");
      chk_mc(15, 16'h0000, "R6 unused level zero");
      for (int i = 0; i < 16; i++) begin
         exp3[i] = 16'(16'h3000 + i * 53);
         mc_write(i, exp3[i]);
      end
      alu(1'b1, 1'b0, 1'b0);
      chk_sig(4, 16'h5301, "R8 carry on level 3");

      // R6 restore of level 0
      do_switch(0, 1'b0);
      for (int i = 0; i < 16; i++) chk_mc(i, exp0[i], "R6 level 0 restored");
      chk_sig(4, 16'h5008, "R10 level 0 byte kept");
      chk_sig(7, 16'd1, "R9 err_irq follows level");

      do_switch(3, 1'b0);
      for (int i = 0; i < 16; i++) chk_mc(i, exp3[i], "R6 level 3 restored");
      chk_sig(4, 16'h5301, "R10 level 3 byte kept");

      // same-level switch
      do_switch(3, 1'b0);
      chk_mc(7, exp3[7], "R6 same level switch");

      // highest level
      do_switch(15, 1'b0);
      chk_sig(4, 16'h5F00, "R7 level field 15");
      chk_mc(3, 16'h0000, "R6 level 15 zero");
      alu(1'b0, 1'b1, 1'b0);
      chk_sig(4, 16'h5F06, "R8 overflow set");
      alu(1'b0, 1'b0, 1'b0);
      chk_sig(4, 16'h5F04, "R8 dynamic follows latest");
      st_write(16'h5000);
      chk_sig(4, 16'h5F00, "R8 static cleared by word write");

      tick();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule